// File: doc/BRIEF.md
# Streaming Hamming Code Generator for 256-Byte Sectors

This block computes the 24-bit single-error-correcting check code for a 256-byte half sector while the data streams past. It takes one byte in every cycle where the valid input is high. It emits the code in the cycle after the last byte is taken, so a storage controller can write the code into the spare area without buffering the sector.

For each byte the block forms six column-parity bits and the byte's overall parity. Column parities are summed by XOR across the block. The index of every byte with odd parity is XORed into an index register, which gives the odd-numbered line parities. The even-numbered line parities come from that same register, complemented when the total parity of the block is odd. At the end of the block the line parities are interleaved and inverted into two code bytes. A third byte carries the inverted column parities.

A start pulse discards any partial block and restarts at byte index 0. After a full block, the next block begins at index 0 with no start pulse needed.

Top module: `ecc256_gen`

## Requirements
- R1: After reset, `done` is 0 and `code` is 24'h000000.
- R2: The column parities of a byte d are CP0=d0^d2^d4^d6, CP1=d1^d3^d5^d7, CP2=d0^d1^d4^d5, CP3=d2^d3^d6^d7, CP4=d0^d1^d2^d3 and CP5=d4^d5^d6^d7. Each is XOR-summed over the block. `code[23:18]` holds the complement of the sums CP5..CP0, with CP5 in bit 23.
- R3: The odd line parity register is the XOR of the 8-bit indices (0..255, in arrival order) of all bytes whose eight bits XOR to 1.
- R4: The even line parity register equals the odd register complemented when the XOR of all data bits in the block is 1, and equals the odd register unchanged otherwise.
- R5: `code[7:0]` is the inversion of {odd7, even7, odd6, even6, odd5, even5, odd4, even4}, MSB first. `code[15:8]` is the inversion of the same pattern over bits 3 down to 0.
- R6: `code[17:16]` is 2'b11 in every produced code.
- R7: `done` is high for exactly one cycle. It rises in the cycle after the clock edge that takes the 256th byte, and it does not rise at any other time.
- R8: Cycles with `in_valid` low and `start` low change neither the byte index nor the accumulated parities.
- R9: `start` discards the partial block. If `in_valid` is high in the same cycle, that byte is taken as index 0 of a new block.
- R10: After a block completes, the next byte taken is index 0 of a fresh block without a start pulse. `code` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Abandon any partial block and restart at index 0 |
| in_valid | input | 1 | Data byte present this cycle |
| in_data | input | 8 | Data byte |
| done | output | 1 | One-cycle pulse: `code` is new |
| code | output | 24 | Check code: [7:0] line byte high, [15:8] line byte low, [23:16] column byte |

## Verification
The only result is the code. It is due exactly one cycle after the edge that takes the 256th byte. The bench samples one time unit after each rising edge and expects `done` in the first such sample after the last byte, with `done` low again in the next one. A scoreboard queue holds one expected code per driven full block. It is computed from direct bitwise line and column sums, and the monitor pops an entry only on `done`. Idle gaps, abandoned blocks and back-to-back blocks therefore shift no result. Hand-worked codes for sparse blocks pin down bit placement.

// File: rtl/ecc256_pkg.sv
`timescale 1ns/1ps
package ecc256_pkg;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 8;
    localparam int BLOCK_LEN = 1 << IDX_W;
    localparam int NUM_CP    = 2 * $clog2(BYTE_W);
    localparam int CODE_W    = 3 * BYTE_W;

    typedef struct packed {
        logic              allpar;
        logic [NUM_CP-1:0] cp;
    } colsum_t;

    // XOR of the data bits whose position has bit 'lvl' equal to 'upper'
    function automatic logic half_xor(input logic [BYTE_W-1:0] d,
                                      input int lvl, input bit upper);
        logic acc;
        acc = 1'b0;
        for (int b = 0; b < BYTE_W; b++) begin
            if (((b >> lvl) & 1) == int'(upper))
                acc = acc ^ d[b];
        end
        return acc;
    endfunction
endpackage

// File: rtl/ecc256_colpar.sv
`timescale 1ns/1ps
module ecc256_colpar
    import ecc256_pkg::*;
(
    input  logic [BYTE_W-1:0] d,
    output colsum_t           cs
);
    localparam int LEVELS = NUM_CP / 2;

    for (genvar g = 0; g < LEVELS; g++) begin : g_pair
        assign cs.cp[2*g]   = half_xor(d, g, 1'b0);
        assign cs.cp[2*g+1] = half_xor(d, g, 1'b1);
    end

    assign cs.allpar = ^d;
endmodule

// File: rtl/ecc256_accum.sv
`timescale 1ns/1ps
module ecc256_accum
    import ecc256_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  colsum_t          cs_in,
    output colsum_t          col_nx,
    output logic [IDX_W-1:0] line_nx,
    output logic             last
);
    colsum_t          col_q;
    logic [IDX_W-1:0] line_q;
    logic [IDX_W-1:0] idx_q;
    colsum_t          col_base;
    logic [IDX_W-1:0] line_base;
    logic [IDX_W-1:0] idx_base;
    logic [IDX_W-1:0] idx_nx;

    always_comb begin
        col_base  = clear ? '0 : col_q;
        line_base = clear ? '0 : line_q;
        idx_base  = clear ? '0 : idx_q;
        col_nx    = take ? (col_base ^ cs_in) : col_base;
        line_nx   = (take && cs_in.allpar) ? (line_base ^ idx_base) : line_base;
        idx_nx    = take ? (idx_base + 1'b1) : idx_base;
        last      = take && (idx_base == IDX_W'(BLOCK_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || last) begin
            col_q  <= '0;
            line_q <= '0;
            idx_q  <= '0;
        end else begin
            col_q  <= col_nx;
            line_q <= line_nx;
            idx_q  <= idx_nx;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> ($stable(idx_q) && $stable(col_q) && $stable(line_q))); // R8
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clear && !take) |=> (idx_q == '0 && col_q == '0 && line_q == '0)); // R9
    AST_WRAP_FRESH: assert property (@(posedge clk) disable iff (rst)
        last |=> (idx_q == '0 && col_q == '0 && line_q == '0)); // R10
endmodule

// File: rtl/ecc256_pack.sv
`timescale 1ns/1ps
module ecc256_pack
    import ecc256_pkg::*;
(
    input  colsum_t           col,
    input  logic [IDX_W-1:0]  odd_line,
    output logic [CODE_W-1:0] code
);
    localparam int HALF = IDX_W / 2;

    logic [IDX_W-1:0]  even_line;
    logic [BYTE_W-1:0] hi_raw;
    logic [BYTE_W-1:0] lo_raw;

    assign even_line = col.allpar ? ~odd_line : odd_line;

    for (genvar j = 0; j < HALF; j++) begin : g_weave
        assign hi_raw[BYTE_W-1-2*j] = odd_line[IDX_W-1-j];
        assign hi_raw[BYTE_W-2-2*j] = even_line[IDX_W-1-j];
        assign lo_raw[BYTE_W-1-2*j] = odd_line[HALF-1-j];
        assign lo_raw[BYTE_W-2-2*j] = even_line[HALF-1-j];
    end

    assign code[BYTE_W-1:0]        = ~hi_raw;
    assign code[2*BYTE_W-1:BYTE_W] = ~lo_raw;
    assign code[CODE_W-1:2*BYTE_W] = {~col.cp, 2'b11};
endmodule

// File: rtl/ecc256_gen.sv
`timescale 1ns/1ps
module ecc256_gen
    import ecc256_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    colsum_t           cs_byte;
    colsum_t           col_nx;
    logic [IDX_W-1:0]  line_nx;
    logic              last;
    logic [CODE_W-1:0] code_nx;

    ecc256_colpar u_colpar (
        .d  (in_data),
        .cs (cs_byte)
    );

    ecc256_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .take    (in_valid),
        .cs_in   (cs_byte),
        .col_nx  (col_nx),
        .line_nx (line_nx),
        .last    (last)
    );

    ecc256_pack u_pack (
        .col      (col_nx),
        .odd_line (line_nx),
        .code     (code_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            code <= '0;
        end else begin
            done <= last;
            if (last)
                code <= code_nx;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(code)); // R10
    AST_LOW_ONES: assert property (@(posedge clk) disable iff (rst)
        done |-> (code[17:16] == 2'b11)); // R6
    AST_VALID_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid)); // R7
endmodule

// File: tb/ecc256_gen_test.sv
`timescale 1ns/1ps
module ecc256_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        done;
    logic [23:0] code;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;
    logic [7:0]  blk [256];
    logic [23:0] exp_q [$];

    always #10 clk = ~clk;

    ecc256_gen uut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_data(in_data), .done(done), .code(code)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent model: direct line and column sums
    function automatic logic [23:0] model();
        logic [7:0] odd_l, even_l, b0, b1;
        logic [5:0] cp;
        logic p;
        odd_l = '0; even_l = '0; cp = '0;
        for (int i = 0; i < 256; i++) begin
            p = ^blk[i];
            for (int k = 0; k < 8; k++) begin
                if (((i >> k) & 1) == 1) odd_l[k] = odd_l[k] ^ p;
                else                     even_l[k] = even_l[k] ^ p;
            end
            for (int b = 0; b < 8; b++)
                for (int s = 0; s < 3; s++)
                    if (((b >> s) & 1) == 1) cp[2*s+1] = cp[2*s+1] ^ blk[i][b];
                    else                     cp[2*s]   = cp[2*s]   ^ blk[i][b];
        end
        for (int j = 0; j < 4; j++) begin
            b0[7-2*j] = odd_l[7-j]; b0[6-2*j] = even_l[7-j];
            b1[7-2*j] = odd_l[3-j]; b1[6-2*j] = even_l[3-j];
        end
        return {~cp, 2'b11, ~b1, ~b0};
    endfunction

    // Drives a block; a full block pushes its expected code first
    task automatic send_block(input int nbytes, input int gap, input bit with_start);
        if (nbytes == 256) exp_q.push_back(model());
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = blk[i];
            start    = with_start && (i == 0);
            if (gap > 0 && (i % gap) == gap - 1 && i != nbytes - 1) begin
                @(negedge clk);
                in_valid = 1'b0; start = 1'b0; in_data = 8'hA5;
                @(negedge clk);
                in_data = 8'h3C;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0; start = 1'b0;
        if (nbytes == 256) begin
            chk(done === 1'b1, "R7 done after last byte", {23'd0, done}, 24'd1);
            @(posedge clk); #1;
            chk(done === 1'b0, "R7 done one cycle", {23'd0, done}, 24'd0);
        end
    endtask

    task automatic fill_zero();
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(posedge clk); #1;
            if (!rst && done) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R7 unexpected done", code, 24'hxxxxxx);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk(code === e, "R2 R3 R4 R5 scoreboard code", code, e);
                end
            end
        end
    end

    initial begin
        #4000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        chk(done === 1'b0, "R1 reset done", {23'd0, done}, 24'd0);
        chk(code === 24'h0, "R1 reset code", code, 24'h0);

        // all zero data
        fill_zero();
        send_block(256, 0, 1'b1);
        chk(code === 24'hFFFFFF, "R2 all-zero block", code, 24'hFFFFFF);

        // one odd byte at index 0
        blk[0] = 8'h01;
        send_block(256, 0, 1'b0);
        chk(code === 24'hABAAAA, "R2 R4 single byte at index 0", code, 24'hABAAAA);

        // one odd byte at index 0xC5, total parity odd
        fill_zero(); blk[8'hC5] = 8'h01;
        send_block(256, 0, 1'b0);
        chk(code === 24'hAB995A, "R3 R5 odd byte at C5", code, 24'hAB995A);

        // two odd bytes: total parity even, even register not complemented
        fill_zero(); blk[8'h10] = 8'h01; blk[8'h03] = 8'h01;
        send_block(256, 0, 1'b0);
        chk(code === 24'hFFF0FC, "R4 even parity total", code, 24'hFFF0FC);
        chk(code[17:16] === 2'b11, "R6 low bits", {22'd0, code[17:16]}, 24'd3);

        // all ones
        for (int i = 0; i < 256; i++) blk[i] = 8'hFF;
        send_block(256, 0, 1'b0);

        // index pattern with idle gaps
        for (int i = 0; i < 256; i++) blk[i] = 8'(i);
        send_block(256, 7, 1'b0);
        chk(code === model(), "R8 gaps do not disturb", code, model());

        // code holds while idle
        held = code;
        repeat (6) @(posedge clk);
        #1;
        chk(code === held, "R10 code holds when idle", code, held);

        // abandoned partial block, then restart with start alone
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 37 + 11) ^ (i >> 3));
        send_block(100, 0, 1'b0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        send_block(256, 0, 1'b0);
        chk(code === model(), "R9 start alone discards partial", code, model());

        // abandoned partial block, restart with start and valid together
        send_block(57, 3, 1'b0);
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 113 + 5) ^ (i << 2));
        send_block(256, 0, 1'b1);
        chk(code === model(), "R9 start with first byte", code, model());

        // back-to-back blocks without start
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 29) ^ 8'h5A);
        send_block(256, 0, 1'b0);
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 71 + 200) ^ (i >> 1));
        send_block(256, 11, 1'b0);
        chk(code === model(), "R10 fresh block after completion", code, model());

        repeat (5) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R7 every block produced done", 24'(exp_q.size()), 24'd0);

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule